// File: doc/BRIEF.md
# Standard-Definition Timing and Subcarrier Reset Controller

This block gives one external control pin three possible meanings, chosen by a 2-bit role field. In counter-hold role, a rising edge on the pin forces the pixel and line counters of a standard-definition timebase to zero. The counters stay at zero while the pin stays high, and they count again from zero once the pin falls. In phase-reset role, a rising edge arms a pending reset of the colour subcarrier phase accumulator. That reset is carried out on the first clock of the next field, so the zero phase lines up with the timebase. In stream role, the pin is only handed on to a downstream stream decoder, together with a select flag.

The block contains a small pixel/line/field timebase and a phase accumulator, so that the effect of the pin can be seen at the ports. The field counter runs through an 8-field colour sequence. A phase reset deliberately leaves it untouched, so its value stays a valid sequence position.

Top module: `sd_timing_reset_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the pixel counter, line counter, field counter, phase accumulator, the pending phase reset and both stream outputs to zero.
- R2: With `role_i` = 2'b00, a rising edge of the pin, seen after a two-flop synchronizer, forces `pix_o` and `line_o` to zero from the third rising clock edge after the pin goes high. They stay at zero while the pin stays high. A pin that is already high when this role is entered, with no new edge, does not hold the counters.
- R3: When not held, `pix_o` counts 0 to H_TOTAL-1 and wraps. `line_o` advances on each pixel wrap and wraps after V_TOTAL-1. After a hold is released, counting resumes from zero.
- R4: A high pulse on the pin that begins and ends between two rising clock edges is not recognised and has no effect on any output.
- R5: With `role_i` = 2'b01, a rising edge of the synchronized pin arms a phase reset. On the clock that starts the next field (`pix_o`=0, `line_o`=0), `phase_o` reads zero. The pending reset is then cleared, so it is applied only once.
- R6: `field_o` advances by one when the line counter wraps, and it wraps from FIELDS-1 back to 0. Neither a phase reset nor a counter hold clears it.
- R7: With `role_i[1]` = 1, `stream_sel_o` is 1 and `stream_bit_o` follows the synchronized pin, three edges after the pin changes. The pin then has no effect on the counters or on the phase. In the other roles, both stream outputs are 0.
- R8: `phase_o` adds `freq_i` on every clock, modulo 2^32, unless a pending reset is being applied.
- R9: In phase-reset role the pin never holds the counters. In counter-hold role it never arms a phase reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin_i | input | 1 | Asynchronous shared control pin |
| role_i | input | 2 | Pin role: 00 counter hold, 01 phase reset, 1x stream |
| freq_i | input | PHASE_W | Phase increment added every clock |
| pix_o | output | clog2(H_TOTAL) | Pixel counter |
| line_o | output | clog2(V_TOTAL) | Line-in-field counter |
| field_o | output | clog2(FIELDS) | Field sequence number |
| phase_o | output | PHASE_W | Subcarrier phase accumulator |
| stream_sel_o | output | 1 | Stream role selected |
| stream_bit_o | output | 1 | Synchronized pin for the stream decoder |

## Verification
The hardest situation to reach is a phase reset landing exactly on a field boundary. To get there, the pin must be armed in phase-reset role, and the bench must then reach the wrap of the last pixel of the last line without any hold interfering. The stimulus arms the reset in the middle of a field and runs past the next field start, where it checks `phase_o` for zero. It also keeps a cycle-by-cycle model of counters, field number and phase that is compared on every clock. A second tricky case is a pin that stays high across a change of role into counter-hold role. The bench raises the pin in phase-reset role, switches the role while the pin stays high, and confirms that the counters keep running.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    PIN_HOLD       = 2'b00,
    PIN_PHASE      = 2'b01,
    PIN_STREAM     = 2'b10,
    PIN_STREAM_ALT = 2'b11
  } pin_role_e;
endpackage

// File: rtl/tsr_pin_sync.sv
module tsr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tsr_timebase.sv
module tsr_timebase #(
  parameter int H_TOTAL = 858,
  parameter int V_TOTAL = 262,
  parameter int FIELDS  = 8,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int FW = $clog2(FIELDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  output logic [HW-1:0] pix_o,
  output logic [VW-1:0] line_o,
  output logic [FW-1:0] field_o,
  output logic          fwrap_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FIELDS - 1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic [FW-1:0] f_q;
  logic          hwrap;

  assign hwrap   = !hold_i && (h_q == H_LAST);
  assign fwrap_o = hwrap && (v_q == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= '0;
    end else if (hold_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (hwrap) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + VW'(1);
    end else begin
      h_q <= h_q + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          f_q <= '0;
    else if (fwrap_o) f_q <= (f_q == F_LAST) ? '0 : f_q + FW'(1);
  end

  assign pix_o   = h_q;
  assign line_o  = v_q;
  assign field_o = f_q;

  assert_pix_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && h_q != H_LAST) |=> (h_q == $past(h_q) + HW'(1)));
  assert_field_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !fwrap_o |=> $stable(f_q));
  assert_field_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (fwrap_o && f_q == F_LAST) |=> (f_q == '0));
endmodule

// File: rtl/tsr_phase_acc.sv
module tsr_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_i,
  input  logic               apply_i,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;
  logic               pend_q;
  logic               fire;

  assign fire = pend_q && apply_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= fire ? '0 : phase_q + freq_i;
      pend_q  <= arm_i || (pend_q && !apply_i);
    end
  end

  assign phase_o = phase_q;

  assert_phase_zero_R5: assert property (@(posedge clk) disable iff (rst)
    fire |=> (phase_q == '0));
  assert_pend_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && !arm_i) |=> !pend_q);
  assert_phase_add_R8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (phase_q == $past(phase_q) + $past(freq_i)));
endmodule

// File: rtl/sd_timing_reset_ctrl.sv
module sd_timing_reset_ctrl
  import tsr_pkg::*;
#(
  parameter int H_TOTAL = 858,
  parameter int V_TOTAL = 262,
  parameter int FIELDS  = 8,
  parameter int PHASE_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int FW = $clog2(FIELDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_pin_i,
  input  logic [1:0]         role_i,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [HW-1:0]      pix_o,
  output logic [VW-1:0]      line_o,
  output logic [FW-1:0]      field_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               stream_sel_o,
  output logic               stream_bit_o
);
  logic level, rise, hold, hold_act_q, fwrap, arm;
  logic sel_q, bit_q;

  tsr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ctl_pin_i), .level_o(level), .rise_o(rise)
  );

  // hold starts only on an edge seen in hold role, then lasts while high
  assign hold = (role_i == PIN_HOLD) && level && (rise || hold_act_q);
  assign arm  = (role_i == PIN_PHASE) && rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_act_q <= 1'b0;
      sel_q      <= 1'b0;
      bit_q      <= 1'b0;
    end else begin
      hold_act_q <= hold;
      sel_q      <= role_i[1];
      bit_q      <= role_i[1] & level;
    end
  end

  tsr_timebase #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .FIELDS(FIELDS)) u_tb (
    .clk(clk), .rst(rst), .hold_i(hold),
    .pix_o(pix_o), .line_o(line_o), .field_o(field_o), .fwrap_o(fwrap)
  );

  tsr_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .arm_i(arm), .apply_i(fwrap),
    .freq_i(freq_i), .phase_o(phase_o)
  );

  assign stream_sel_o = sel_q;
  assign stream_bit_o = bit_q;

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (role_i == PIN_HOLD && level && hold_act_q) |=> (pix_o == '0 && line_o == '0));
  assert_stream_off_R7: assert property (@(posedge clk) disable iff (rst)
    !role_i[1] |=> (!stream_sel_o && !stream_bit_o));
  assert_no_hold_phase_R9: assert property (@(posedge clk) disable iff (rst)
    (role_i == PIN_PHASE && pix_o != HW'(H_TOTAL - 1)) |=> (pix_o == $past(pix_o) + HW'(1)));
endmodule

// File: tb/sd_timing_reset_ctrl_bench.sv
module sd_timing_reset_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;
  localparam int V = 4;
  localparam int F = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic [1:0] role = 2'b00;
  logic [31:0] freq = 32'h0;
  logic [3:0] pix;
  logic [1:0] line;
  logic [2:0] field;
  logic [31:0] phase;
  logic ssel, sbit;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  sd_timing_reset_ctrl #(.H_TOTAL(H), .V_TOTAL(V), .FIELDS(F), .PHASE_W(32)) u_sd_timing_reset_ctrl (
    .clk(clk), .rst(rst), .ctl_pin_i(pin), .role_i(role), .freq_i(freq),
    .pix_o(pix), .line_o(line), .field_o(field), .phase_o(phase),
    .stream_sel_o(ssel), .stream_bit_o(sbit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int h; int v; int f; logic [31:0] ph; logic ss; logic sb;
  } exp_t;
  exp_t sb_q[$];

  int mh, mv, mf;
  logic [31:0] mph;
  logic ms1, ms2, ms3, mact, mpend, mss, msb;

  // reference model from the requirements; pushes one expected item per edge
  always @(posedge clk) begin
    logic rise, hold, fw;
    exp_t e;
    if (rst) begin
      mh = 0; mv = 0; mf = 0; mph = 0;
      ms1 = 0; ms2 = 0; ms3 = 0; mact = 0; mpend = 0; mss = 0; msb = 0;
    end else begin
      rise = ms2 & ~ms3;
      hold = (role == 2'b00) && ms2 && (rise || mact);
      fw   = !hold && mh == H-1 && mv == V-1;
      if (mpend && fw) mph = 0; else mph = mph + freq;
      mpend = ((role == 2'b01) && rise) || (mpend && !fw);
      if (fw) mf = (mf + 1) % F;
      if (hold) begin mh = 0; mv = 0; end
      else if (mh == H-1) begin mh = 0; mv = (mv == V-1) ? 0 : mv + 1; end
      else mh = mh + 1;
      mact = hold;
      msb = role[1] & ms2;
      mss = role[1];
      ms3 = ms2; ms2 = ms1; ms1 = pin;
    end
    e.h = mh; e.v = mv; e.f = mf; e.ph = mph; e.ss = mss; e.sb = msb;
    sb_q.push_back(e);
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      compared++;
      if (int'(pix) != e.h || int'(line) != e.v || int'(field) != e.f ||
          phase != e.ph || ssel != e.ss || sbit != e.sb) begin
        mismatched++;
        $display("FAIL %s: pix/line/field/phase/sel/bit = %0d/%0d/%0d/%h/%b/%b expected %0d/%0d/%0d/%h/%b/%b",
                 tag, pix, line, field, phase, ssel, sbit, e.h, e.v, e.f, e.ph, e.ss, e.sb);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cycles(3);
    chk("R1", pix, 0); chk("R1", line, 0); chk("R1", field, 0);
    chk("R1", phase, 0); chk("R1", ssel, 0);
    rst = 1'b0;
    freq = 32'h0123_4567;

    tag = "R3"; cycles(60);

    // R2: hold while high, resume from zero on release
    tag = "R2"; pin = 1'b1; cycles(8);
    chk("R2", pix, 0); chk("R2", line, 0);
    pin = 1'b0; tag = "R3"; cycles(2);
    chk("R3", pix, 0);
    cycles(1);
    chk("R3", pix, 1);
    cycles(30);

    // R4: pulse entirely between two rising edges
    tag = "R4";
    @(negedge clk); #1 pin = 1'b1; #2 pin = 1'b0;
    cycles(6);
    chk("R4", sbit, 0);
    cycles(14);

    // R9 and R2: pin high in phase role, then role changes with no new edge
    tag = "R9"; role = 2'b01; pin = 1'b1; cycles(6);
    tag = "R2"; role = 2'b00; cycles(6);
    pin = 1'b0; cycles(4);

    // R5 and R8: arm mid-field, check phase zero at next field start
    tag = "R8"; freq = 32'hF000_0001; role = 2'b01;
    while (!(pix == 4 && line == 1)) @(negedge clk);
    tag = "R5"; pin = 1'b1; cycles(3); pin = 1'b0; cycles(3);
    while (!(pix == 0 && line == 0)) @(negedge clk);
    chk("R5", phase, 0);
    tag = "R6"; cycles(50);
    chk("R5", phase == 0, 0);

    // R7: stream role passes the pin through
    tag = "R7"; role = 2'b10; cycles(2);
    chk("R7", ssel, 1);
    pin = 1'b1; cycles(3); chk("R7", sbit, 1);
    pin = 1'b0; cycles(3); chk("R7", sbit, 0);
    pin = 1'b1; cycles(7); pin = 1'b0; cycles(5);

    // R6: long run across a full field sequence wrap
    tag = "R6"; role = 2'b00; freq = 32'h0000_1001; cycles(F * H * V + 30);

    cycles(2);
    finish_run();
  end
endmodule